// File: doc/BRIEF.md
# Two-Priority Link Framing Transmitter

This block is the transmit side of a point-to-point link that carries both urgent short messages (trigger, busy and similar) and framed bulk traffic (data and control packets) over one serial lane. It produces one 8-bit symbol per clock, each with a control flag, for an 8b/10b encoder further down the line. The coder, the serialiser and the line drivers sit outside this block. The 8b/10b coding costs a fifth of the raw line rate, so every symbol slot matters.

A high-priority message is the fixed pair {marker control symbol, one data byte}. It always appears exactly one clock after its request, whatever the bulk channel is doing. The bulk channel sends frames of the form {start control symbol, length byte, payload bytes, end control symbol}. A high-priority pair may cut into a frame between any two of its symbols, and the frame then carries on with its next symbol. When the far end withdraws its ready signal, the bulk channel stops but urgent messages still go out. The idle control symbol fills every slot that has nothing else to carry, so the receiver discards it wherever it appears, including inside a frame.

The bulk framer is a four-state machine. FR_IDLE moves to FR_LEN when it sends the start symbol and acknowledges the request. FR_LEN moves to FR_PAY after the length byte, or straight to FR_END when the length is zero. FR_PAY stays in FR_PAY until the last byte has been taken and then moves to FR_END. FR_END returns to FR_IDLE once the end symbol has been sent. Each of these moves happens only in a slot the framer owns, which is a slot where the far end is ready and no urgent pair is being sent.

Top module: `link_tx_framer`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `tx_sym` is the idle code 0xBC with `tx_k`=1, and `lp_ack` and `lp_take` are 0.
- R2: Any slot that carries neither an urgent symbol nor a bulk symbol carries the idle code 0xBC with `tx_k`=1.
- R3: When `hp_valid` is sampled high at a clock edge, the marker 0x3C with `tx_k`=1 is output after that edge. After the next edge the sampled `hp_data` byte is output with `tx_k`=0. This latency is the same under any bulk traffic.
- R4: An urgent pair may cut into a frame between any two of its symbols. The frame then continues with the symbol that would have come next, so that once the urgent pairs and idles are removed it matches the frame that was requested, byte for byte.
- R5: A frame is 0xFB with `tx_k`=1, then the length byte (`tx_k`=0, equal to `lp_len`), then exactly that many payload bytes taken from `lp_data` in order (`tx_k`=0), then 0xFD with `tx_k`=1.
- R6: A request with `lp_len`=0 produces the start symbol, a length byte of 0 and the end symbol, and no payload byte is taken.
- R7: While `rx_ready` is 0, no bulk symbol is started: `lp_ack` and `lp_take` stay 0, and urgent pairs are still sent as in R3.
- R8: `lp_ack` is high in exactly the cycle whose edge sends the start symbol. `lp_take` is high in exactly the cycles whose edges send a payload byte, and the source advances `lp_data` on those edges.
- R9: While `hp_valid` is high or an urgent payload byte is pending, the bulk channel is held: `lp_ack` and `lp_take` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hp_valid | input | 1 | Urgent message request, one-cycle pulse, at least two cycles apart |
| hp_data | input | 8 | Urgent message byte, valid with `hp_valid` |
| lp_req | input | 1 | Bulk frame request, held until `lp_ack` |
| lp_len | input | 8 | Payload length of the requested frame |
| lp_data | input | 8 | Current payload byte (show-ahead source) |
| rx_ready | input | 1 | Far end can accept bulk symbols |
| lp_ack | output | 1 | Frame request accepted (start symbol sent at this edge) |
| lp_take | output | 1 | Payload byte consumed at this edge |
| tx_sym | output | 8 | Symbol byte to the encoder |
| tx_k | output | 1 | Symbol is a control code |

## Verification
Frames of every length from 0 to 10 are each sent with one urgent message placed at every offset from 0 to 13 cycles after the request, so the cut-in lands on the start symbol, the length byte, each payload position, the end symbol and the idle time after the frame. Even offsets add a second message two cycles later, the tightest legal spacing. Every third combination also drops `rx_ready` one cycle in five. A further case holds `rx_ready` low across a pending request while an urgent message passes. Together these runs separate a wrong urgent latency, a lost or repeated byte after preemption, a mishandled zero length and a leak of bulk traffic during a stall.

// File: rtl/link_tx_pkg.sv
package link_tx_pkg;
    localparam int SYM_W = 8;

    localparam logic [SYM_W-1:0] CODE_IDLE = 8'hBC;
    localparam logic [SYM_W-1:0] CODE_MARK = 8'h3C;
    localparam logic [SYM_W-1:0] CODE_SOF  = 8'hFB;
    localparam logic [SYM_W-1:0] CODE_EOF  = 8'hFD;

    typedef struct packed {
        logic             k;
        logic [SYM_W-1:0] d;
    } sym_t;

    typedef enum logic [1:0] {
        FR_IDLE,
        FR_LEN,
        FR_PAY,
        FR_END
    } fr_state_t;
endpackage

// File: rtl/hp_slot.sv
module hp_slot
    import link_tx_pkg::*;
#(
    parameter int W = SYM_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         hp_valid,
    input  logic [W-1:0] hp_data,
    output logic         pend,
    output logic [W-1:0] pend_data,
    output logic         busy
);
    // Holds the payload byte of an urgent pair for its second slot.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend      <= 1'b0;
            pend_data <= '0;
        end else begin
            pend <= hp_valid;
            if (hp_valid) pend_data <= hp_data;
        end
    end

    always_comb begin
        busy = hp_valid | pend;
    end
endmodule

// File: rtl/lp_framer.sv
module lp_framer
    import link_tx_pkg::*;
#(
    parameter int W = SYM_W,
    parameter logic [W-1:0] SOF_CODE = CODE_SOF,
    parameter logic [W-1:0] EOF_CODE = CODE_EOF
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         own_slot,
    input  logic         lp_req,
    input  logic [W-1:0] lp_len,
    input  logic [W-1:0] lp_data,
    output logic         lp_ack,
    output logic         lp_take,
    output logic         emit,
    output logic         sym_k,
    output logic [W-1:0] sym_d
);
    fr_state_t    st, st_nxt;
    logic [W-1:0] len_q;
    logic [W-1:0] rem_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st    <= FR_IDLE;
            len_q <= '0;
            rem_q <= '0;
        end else begin
            st <= st_nxt;
            if (lp_ack) len_q <= lp_len;
            if (own_slot && st == FR_LEN) rem_q <= len_q;
            else if (lp_take) rem_q <= rem_q - 1'b1;
        end
    end

    // next state
    always_comb begin
        st_nxt = st;
        unique case (st)
            FR_IDLE: if (own_slot && lp_req) st_nxt = FR_LEN;
            FR_LEN:  if (own_slot) st_nxt = (len_q == '0) ? FR_END : FR_PAY;
            FR_PAY:  if (own_slot && rem_q == W'(1)) st_nxt = FR_END;
            FR_END:  if (own_slot) st_nxt = FR_IDLE;
            default: st_nxt = FR_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        lp_ack  = 1'b0;
        lp_take = 1'b0;
        emit    = 1'b0;
        sym_k   = 1'b1;
        sym_d   = SOF_CODE;
        unique case (st)
            FR_IDLE: begin
                emit   = own_slot && lp_req;
                lp_ack = own_slot && lp_req;
            end
            FR_LEN: begin
                emit  = own_slot;
                sym_k = 1'b0;
                sym_d = len_q;
            end
            FR_PAY: begin
                emit    = own_slot;
                lp_take = own_slot;
                sym_k   = 1'b0;
                sym_d   = lp_data;
            end
            FR_END: begin
                emit  = own_slot;
                sym_d = EOF_CODE;
            end
            default: emit = 1'b0;
        endcase
    end
endmodule

// File: rtl/sym_out.sv
module sym_out
    import link_tx_pkg::*;
#(
    parameter int W = SYM_W,
    parameter logic [W-1:0] IDLE_CODE = CODE_IDLE,
    parameter logic [W-1:0] MARK_CODE = CODE_MARK
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         hp_valid,
    input  logic         pend,
    input  logic [W-1:0] pend_data,
    input  logic         lp_emit,
    input  logic         lp_k,
    input  logic [W-1:0] lp_d,
    output logic         tx_k,
    output logic [W-1:0] tx_sym
);
    logic         k_nxt;
    logic [W-1:0] d_nxt;

    // priority: marker, urgent payload, bulk symbol, idle
    always_comb begin
        if (hp_valid) begin
            k_nxt = 1'b1;
            d_nxt = MARK_CODE;
        end else if (pend) begin
            k_nxt = 1'b0;
            d_nxt = pend_data;
        end else if (lp_emit) begin
            k_nxt = lp_k;
            d_nxt = lp_d;
        end else begin
            k_nxt = 1'b1;
            d_nxt = IDLE_CODE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_k   <= 1'b1;
            tx_sym <= IDLE_CODE;
        end else begin
            tx_k   <= k_nxt;
            tx_sym <= d_nxt;
        end
    end
endmodule

// File: rtl/link_tx_framer.sv
module link_tx_framer
    import link_tx_pkg::*;
#(
    parameter int W = SYM_W,
    parameter logic [W-1:0] IDLE_CODE = CODE_IDLE,
    parameter logic [W-1:0] MARK_CODE = CODE_MARK,
    parameter logic [W-1:0] SOF_CODE  = CODE_SOF,
    parameter logic [W-1:0] EOF_CODE  = CODE_EOF
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         hp_valid,
    input  logic [W-1:0] hp_data,
    input  logic         lp_req,
    input  logic [W-1:0] lp_len,
    input  logic [W-1:0] lp_data,
    input  logic         rx_ready,
    output logic         lp_ack,
    output logic         lp_take,
    output logic [W-1:0] tx_sym,
    output logic         tx_k
);
    logic         pend;
    logic [W-1:0] pend_data;
    logic         hp_busy;
    logic         own_slot;
    logic         lp_emit;
    logic         lp_k;
    logic [W-1:0] lp_d;

    hp_slot #(.W(W)) u_hp (
        .clk       (clk),
        .rst_n     (rst_n),
        .hp_valid  (hp_valid),
        .hp_data   (hp_data),
        .pend      (pend),
        .pend_data (pend_data),
        .busy      (hp_busy)
    );

    always_comb begin
        own_slot = rx_ready && !hp_busy;
    end

    lp_framer #(.W(W), .SOF_CODE(SOF_CODE), .EOF_CODE(EOF_CODE)) u_fr (
        .clk      (clk),
        .rst_n    (rst_n),
        .own_slot (own_slot),
        .lp_req   (lp_req),
        .lp_len   (lp_len),
        .lp_data  (lp_data),
        .lp_ack   (lp_ack),
        .lp_take  (lp_take),
        .emit     (lp_emit),
        .sym_k    (lp_k),
        .sym_d    (lp_d)
    );

    sym_out #(.W(W), .IDLE_CODE(IDLE_CODE), .MARK_CODE(MARK_CODE)) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .hp_valid  (hp_valid),
        .pend      (pend),
        .pend_data (pend_data),
        .lp_emit   (lp_emit),
        .lp_k      (lp_k),
        .lp_d      (lp_d),
        .tx_k      (tx_k),
        .tx_sym    (tx_sym)
    );
endmodule

// File: rtl/link_tx_framer_chk.sv
module link_tx_framer_chk
    import link_tx_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             hp_valid,
    input logic [SYM_W-1:0] hp_data,
    input logic             rx_ready,
    input logic             lp_ack,
    input logic             lp_take,
    input logic [SYM_W-1:0] tx_sym,
    input logic             tx_k
);
    // R3: marker follows a request by one edge
    a_r3_marker: assert property (@(posedge clk) disable iff (!rst_n)
        hp_valid |=> (tx_k && tx_sym == CODE_MARK));

    // R3: the payload byte follows the marker
    a_r3_payload: assert property (@(posedge clk) disable iff (!rst_n)
        hp_valid |=> ##1 (!tx_k && tx_sym == $past(hp_data, 2)));

    // R7: nothing bulk starts while the far end is not ready
    a_r7_stall: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_ready |-> (!lp_ack && !lp_take));

    // R9: an urgent request holds the bulk channel
    a_r9_hp_holds: assert property (@(posedge clk) disable iff (!rst_n)
        hp_valid |-> (!lp_ack && !lp_take));

    // R9: the urgent payload slot also holds the bulk channel
    a_r9_pend_holds: assert property (@(posedge clk) disable iff (!rst_n)
        $past(hp_valid) |-> (!lp_ack && !lp_take));

    // R8: acceptance and byte take never share an edge
    a_r8_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(lp_ack && lp_take));

    // R2: control symbols are only the four defined codes
    a_r2_codes: assert property (@(posedge clk) disable iff (!rst_n)
        tx_k |-> (tx_sym == CODE_IDLE || tx_sym == CODE_MARK ||
                  tx_sym == CODE_SOF  || tx_sym == CODE_EOF));
endmodule

bind link_tx_framer link_tx_framer_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .hp_valid (hp_valid),
    .hp_data  (hp_data),
    .rx_ready (rx_ready),
    .lp_ack   (lp_ack),
    .lp_take  (lp_take),
    .tx_sym   (tx_sym),
    .tx_k     (tx_k)
);

// File: tb/link_tx_framer_tb.sv
module link_tx_framer_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       hp_valid = 1'b0;
    logic [7:0] hp_data = 8'h00;
    logic       lp_req = 1'b0;
    logic [7:0] lp_len = 8'h00;
    logic [7:0] lp_data;
    logic       rx_ready = 1'b1;
    logic       lp_ack, lp_take, tx_k;
    logic [7:0] tx_sym;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #2.5 clk = ~clk;

    link_tx_framer u_dut (
        .clk(clk), .rst_n(rst_n), .hp_valid(hp_valid), .hp_data(hp_data),
        .lp_req(lp_req), .lp_len(lp_len), .lp_data(lp_data), .rx_ready(rx_ready),
        .lp_ack(lp_ack), .lp_take(lp_take), .tx_sym(tx_sym), .tx_k(tx_k)
    );

    function automatic logic [7:0] pay(int id, int i);
        return 8'((id * 37 + i * 11 + 5) & 255);
    endfunction

    task automatic check(bit ok, string req, int act, int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // source model and edge samples
    int         tx_id = 0;
    int         src_idx = 0;
    bit         acked = 1'b0;
    bit         hp_s1 = 1'b0, hp_s2 = 1'b0, rdy_s = 1'b1, ack_s = 1'b0, take_s = 1'b0;
    logic [7:0] hd1 = 8'h00, hd2 = 8'h00;
    int         exp_len [256];

    assign lp_data = pay(tx_id, src_idx);

    always @(posedge clk) begin
        if (lp_ack) begin
            acked   <= 1'b1;
            src_idx <= 0;
        end else if (lp_take) begin
            src_idx <= src_idx + 1;
        end
        hp_s1  <= rst_n && hp_valid;
        hp_s2  <= hp_s1;
        hd1    <= hp_data;
        hd2    <= hd1;
        rdy_s  <= rx_ready;
        ack_s  <= rst_n && lp_ack;
        take_s <= rst_n && lp_take;
    end

    // receiver model
    int frames_done = 0;
    bit in_frame = 1'b0, got_len = 1'b0;
    int rx_len = 0, rx_cnt = 0;
    bit mon_on = 1'b0;

    always @(negedge clk) begin
        if (mon_on) begin
            if (hp_s1) begin
                check(tx_k && tx_sym == 8'h3C, "R3 marker", {tx_k, tx_sym}, 9'h13C);
            end else if (hp_s2) begin
                check(!tx_k && tx_sym == hd2, "R3 payload", {tx_k, tx_sym}, {1'b0, hd2});
            end else begin
                if (!rdy_s)
                    check(tx_k && tx_sym == 8'hBC, "R7 stall idle", {tx_k, tx_sym}, 9'h1BC);
                check((tx_k && tx_sym == 8'hFB) == ack_s, "R8 ack with start",
                      ack_s, int'(tx_k && tx_sym == 8'hFB));
                if (tx_k && tx_sym == 8'hBC) begin
                    // idle slot: nothing to reassemble
                end else if (tx_k && tx_sym == 8'hFB) begin
                    check(!in_frame, "R5 start outside frame", in_frame, 0);
                    in_frame = 1'b1;
                    got_len  = 1'b0;
                    rx_cnt   = 0;
                end else if (tx_k && tx_sym == 8'hFD) begin
                    check(in_frame && got_len && rx_cnt == rx_len, "R4 frame byte count",
                          rx_cnt, rx_len);
                    if (rx_len == 0) check(rx_cnt == 0, "R6 empty frame", rx_cnt, 0);
                    in_frame = 1'b0;
                    frames_done++;
                end else if (!tx_k) begin
                    if (!in_frame) begin
                        check(1'b0, "R2 data outside frame", tx_sym, 8'hBC);
                    end else if (!got_len) begin
                        rx_len  = int'(tx_sym);
                        got_len = 1'b1;
                        check(rx_len == exp_len[frames_done & 255], "R5 length byte",
                              rx_len, exp_len[frames_done & 255]);
                        check(!take_s, "R6 no take on length", take_s, 0);
                    end else begin
                        check(tx_sym == pay(frames_done, rx_cnt), "R4 payload byte",
                              tx_sym, pay(frames_done, rx_cnt));
                        check(take_s, "R8 take with payload", take_s, 1);
                        rx_cnt++;
                    end
                end else begin
                    check(1'b0, "R2 unknown control code", tx_sym, 8'hBC);
                end
            end
        end
    end

    task automatic run_frame(int id, int len, int k, bit stall);
        int t;
        @(negedge clk);
        exp_len[id & 255] = len;
        tx_id  = id;
        acked  = 1'b0;
        lp_req = 1'b1;
        lp_len = 8'(len);
        t = 0;
        while (t < 90 && !(frames_done > id && t > k + 4)) begin
            hp_valid = (t == k) || ((k % 2) == 0 && t == k + 2);
            hp_data  = 8'((id * 3 + t) & 255);
            rx_ready = stall ? ((t % 5) != 3) : 1'b1;
            @(negedge clk);
            if (acked) lp_req = 1'b0;
            t++;
        end
        check(frames_done > id, "R4 frame completed", frames_done, id + 1);
        hp_valid = 1'b0;
        rx_ready = 1'b1;
        lp_req   = 1'b0;
    endtask

    initial begin
        int id;
        // R1: reset state
        repeat (3) @(negedge clk);
        check(tx_k && tx_sym == 8'hBC, "R1 reset symbol", {tx_k, tx_sym}, 9'h1BC);
        check(!lp_ack && !lp_take, "R1 reset handshake", {lp_ack, lp_take}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(tx_k && tx_sym == 8'hBC, "R1 first symbol", {tx_k, tx_sym}, 9'h1BC);
        mon_on = 1'b1;
        // R2: idle with nothing to send
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            check(tx_k && tx_sym == 8'hBC, "R2 idle fill", {tx_k, tx_sym}, 9'h1BC);
        end
        // R3 R4 R5 R6 R7: sweep length, preemption offset and stall pattern
        id = 0;
        for (int len = 0; len <= 10; len++) begin
            for (int k = 0; k <= 13; k++) begin
                run_frame(id, len, k, ((len + k) % 3) == 0);
                id++;
            end
        end
        // R7: request held back by a long stall while an urgent message passes
        @(negedge clk);
        exp_len[id & 255] = 3;
        tx_id    = id;
        acked    = 1'b0;
        rx_ready = 1'b0;
        lp_req   = 1'b1;
        lp_len   = 8'd3;
        for (int t = 0; t < 10; t++) begin
            hp_valid = (t == 4);
            hp_data  = 8'h5A;
            @(negedge clk);
        end
        check(!acked && frames_done == id, "R7 no start while stalled", frames_done, id);
        rx_ready = 1'b1;
        for (int t = 0; t < 20 && frames_done == id; t++) begin
            @(negedge clk);
            if (acked) lp_req = 1'b0;
        end
        lp_req = 1'b0;
        check(frames_done == id + 1, "R7 frame after release", frames_done, id + 1);
        repeat (3) @(negedge clk);
        check(tx_k && tx_sym == 8'hBC, "R2 idle after traffic", {tx_k, tx_sym}, 9'h1BC);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule